// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a logical address (a 16-bit selector and a 32-bit offset) into a 32-bit linear address. The selector names one 8-byte descriptor in either the global or the local descriptor table. The block first checks that the entry lies inside the chosen table. It then fetches the 64-bit descriptor over a memory read port and tests it for the requested access. On success it returns segment base plus offset. On failure it returns a fault cause code.

One request is handled at a time. A request is accepted while the block is idle. The block then walks through table-bound check, fetch, descriptor check and an optional write-back, and ends with a one-cycle completion pulse. When a segment is used for the first time, the descriptor is written back with its accessed flag set. Expand-down data segments invert the offset test. Conforming code segments relax the privilege rule.

Top module: `seg_xlat`

## Requirements
- R1: Selector bits 15:3 are the entry index and bit 2 picks the table (0 global, 1 local). Bits 1:0 are the requested privilege. The descriptor is read from table base + index*8, using the table registers sampled when the request is accepted.
- R2: If index*8+7 is greater than the chosen table limit, the request ends with fault code 1 and no memory read is issued.
- R3: Descriptor layout: limit = {bits 51:48, bits 15:0}, base = {bits 63:56, bits 39:32, bits 31:16}. On success fault is 0, the code is 0 and lin_addr = base + offset (modulo 2^32). On any fault lin_addr is 0.
- R4: A descriptor whose present bit (bit 47) is 0 gives fault code 2.
- R5: Bit 44 = 0 marks a system descriptor, and any access to it gives fault code 3. Type bits 43:40: bit 43 = code. For data, bit 42 = expand-down and bit 41 = writable. For code, bit 42 = conforming and bit 41 = readable. Access encoding: 0 read, 1 write, 2 or 3 execute. Fault code 3 also results from a write to code, a read of non-readable code, execute of data, or a write to non-writable data.
- R6: Privilege uses DPL = bits 46:45 and gives fault code 4. For data, max(CPL, RPL) must not exceed DPL. For non-conforming code, DPL must equal CPL. For conforming code, DPL must not exceed CPL.
- R7: For an expand-down data segment the offset must be greater than the limit. For every other segment it must be less than or equal to the limit. A violation gives fault code 5.
- R8: When several checks fail, the reported cause follows the order table bound, present, type, privilege, limit.
- R9: A successful access to a descriptor whose accessed bit (bit 40) is 0 causes exactly one write of that descriptor with bit 40 set, to the same address, before completion. Otherwise nothing is written.
- R10: After reset busy, done, mem_rd_en and mem_wr_en are 0. A request is taken when req_valid is high and busy is low. busy stays high until done, and done is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 16 | Selector |
| req_off | input | 32 | Offset within segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| req_cpl | input | 2 | Current privilege level |
| gtab_base | input | 32 | Global table base |
| gtab_limit | input | 16 | Global table limit (last valid byte) |
| ltab_base | input | 32 | Local table base |
| ltab_limit | input | 16 | Local table limit |
| busy | output | 1 | Translation in progress |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Result is a fault |
| fault_code | output | 3 | 0 none, 1 table, 2 absent, 3 type, 4 privilege, 5 limit |
| lin_addr | output | 32 | Linear address |
| mem_rd_en | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Read descriptor |
| mem_wr_en | output | 1 | Accessed-flag write-back strobe |
| mem_wr_addr | output | 32 | Write-back address |
| mem_wr_data | output | 64 | Descriptor with accessed bit set |

## Verification
Some properties are checked by assertions on every cycle. These cover the completion pulse and the busy window, the rule that read and write never overlap, and the rule that a write-back always carries the accessed bit and targets the address just read. They also check that a table-bound fault never reaches memory and that no fault is ever preceded by a write-back. The bench scenarios are needed for the rest. They show the field layout, the exact cause chosen when several checks fail at once, the boundary offsets of normal and expand-down segments, the privilege rules for each segment kind, and that a second access to the same segment leaves memory untouched.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int SEL_W  = 16;
  localparam int AW     = 32;
  localparam int DW     = 64;
  localparam int TLIM_W = 16;
  localparam int IDX_W  = SEL_W - 3;
  localparam int LIM_W  = 20;
  localparam int ACC_BIT = 40;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_TABLE  = 3'd1,
    FLT_ABSENT = 3'd2,
    FLT_TYPE   = 3'd3,
    FLT_PRIV   = 3'd4,
    FLT_LIMIT  = 3'd5
  } flt_e;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] limit;
    logic [3:0]    typ;
    logic          usr;
    logic [1:0]    dpl;
    logic          present;
  } seg_desc_t;

  function automatic seg_desc_t unpack_desc(input logic [DW-1:0] d);
    seg_desc_t r;
    r.base    = {d[63:56], d[39:32], d[31:16]};
    r.limit   = {{(AW-LIM_W){1'b0}}, d[51:48], d[15:0]};
    r.typ     = d[43:40];
    r.usr     = d[44];
    r.dpl     = d[46:45];
    r.present = d[47];
    return r;
  endfunction

  function automatic logic [AW-1:0] entry_offset(input logic [IDX_W-1:0] idx);
    return {{(AW-IDX_W-3){1'b0}}, idx, 3'b000};
  endfunction

  function automatic logic [TLIM_W-1:0] entry_end(input logic [IDX_W-1:0] idx);
    return {idx, 3'b111};
  endfunction

  // typ[3] code, typ[2] expand-down/conforming, typ[1] writable/readable
  function automatic logic type_allows(input logic [3:0] typ, input logic [1:0] acc);
    logic is_exec, is_wr;
    is_exec = acc[1];
    is_wr   = (acc == 2'd1);
    if (typ[3]) return !is_wr && (is_exec || typ[1]);
    else        return !is_exec && (!is_wr || typ[1]);
  endfunction

  function automatic logic priv_allows(input logic [3:0] typ, input logic [1:0] dpl,
                                       input logic [1:0] cpl, input logic [1:0] rpl);
    logic [1:0] eff;
    eff = (cpl > rpl) ? cpl : rpl;
    if (!typ[3])     return eff <= dpl;
    else if (typ[2]) return dpl <= cpl;
    else             return dpl == cpl;
  endfunction

  function automatic logic limit_allows(input logic [3:0] typ, input logic [AW-1:0] lim,
                                        input logic [AW-1:0] off);
    if (!typ[3] && typ[2]) return off > lim;
    else                   return off <= lim;
  endfunction
endpackage

// File: rtl/segx_tbl_addr.sv
module segx_tbl_addr
  import segx_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [AW-1:0]     gbase,
  input  logic [TLIM_W-1:0] glim,
  input  logic [AW-1:0]     lbase,
  input  logic [TLIM_W-1:0] llim,
  output logic [AW-1:0]     daddr,
  output logic              overrun
);
  logic [IDX_W-1:0]  idx;
  logic              use_local;
  logic [AW-1:0]     tbase;
  logic [TLIM_W-1:0] tlim;
  logic [1:0]        unused_rpl;

  assign idx        = sel[SEL_W-1:3];
  assign use_local  = sel[2];
  assign unused_rpl = sel[1:0];
  assign tbase      = use_local ? lbase : gbase;
  assign tlim       = use_local ? llim  : glim;
  assign daddr      = tbase + entry_offset(idx);
  assign overrun    = entry_end(idx) > tlim;
endmodule

// File: rtl/segx_desc_check.sv
module segx_desc_check
  import segx_pkg::*;
(
  input  logic [DW-1:0] desc,
  input  logic [1:0]    acc,
  input  logic [1:0]    cpl,
  input  logic [1:0]    rpl,
  input  logic [AW-1:0] off,
  output logic [2:0]    code,
  output logic [AW-1:0] lin,
  output logic          needs_wb
);
  seg_desc_t f;
  logic      type_ok, priv_ok, lim_ok;
  logic [3:0] unused_bits;

  assign f           = unpack_desc(desc);
  assign unused_bits = desc[55:52];
  assign type_ok     = f.usr && type_allows(f.typ, acc);
  assign priv_ok     = priv_allows(f.typ, f.dpl, cpl, rpl);
  assign lim_ok      = limit_allows(f.typ, f.limit, off);
  assign lin         = f.base + off;
  assign needs_wb    = !f.typ[0];

  always_comb begin
    if (!f.present)    code = FLT_ABSENT;
    else if (!type_ok) code = FLT_TYPE;
    else if (!priv_ok) code = FLT_PRIV;
    else if (!lim_ok)  code = FLT_LIMIT;
    else               code = FLT_NONE;
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import segx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [AW-1:0]     req_off,
  input  logic [1:0]        req_acc,
  input  logic [1:0]        req_cpl,
  input  logic [AW-1:0]     gtab_base,
  input  logic [TLIM_W-1:0] gtab_limit,
  input  logic [AW-1:0]     ltab_base,
  input  logic [TLIM_W-1:0] ltab_limit,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [2:0]        fault_code,
  output logic [AW-1:0]     lin_addr,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [DW-1:0]     mem_wr_data
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_CHECK, S_WBACK, S_RESP
  } st_e;

  st_e           state;
  logic [AW-1:0] off_q, addr_q, lin_q;
  logic [1:0]    acc_q, cpl_q, rpl_q;
  logic [DW-1:0] desc_q;
  logic [2:0]    code_q;

  // named internal events
  logic          accept_ev;
  logic          tbl_overrun;
  logic [AW-1:0] tbl_daddr;
  logic [2:0]    chk_code;
  logic [AW-1:0] chk_lin;
  logic          chk_wb;

  assign accept_ev = (state == S_IDLE) && req_valid;

  segx_tbl_addr u_tbl (
    .sel(req_sel), .gbase(gtab_base), .glim(gtab_limit),
    .lbase(ltab_base), .llim(ltab_limit),
    .daddr(tbl_daddr), .overrun(tbl_overrun)
  );

  segx_desc_check u_chk_logic (
    .desc(desc_q), .acc(acc_q), .cpl(cpl_q), .rpl(rpl_q), .off(off_q),
    .code(chk_code), .lin(chk_lin), .needs_wb(chk_wb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      off_q  <= '0;
      addr_q <= '0;
      lin_q  <= '0;
      acc_q  <= '0;
      cpl_q  <= '0;
      rpl_q  <= '0;
      desc_q <= '0;
      code_q <= FLT_NONE;
    end else begin
      case (state)
        S_IDLE: if (accept_ev) begin
          off_q  <= req_off;
          acc_q  <= req_acc;
          cpl_q  <= req_cpl;
          rpl_q  <= req_sel[1:0];
          addr_q <= tbl_daddr;
          lin_q  <= '0;
          if (tbl_overrun) begin
            code_q <= FLT_TABLE;
            state  <= S_RESP;
          end else begin
            code_q <= FLT_NONE;
            state  <= S_FETCH;
          end
        end
        S_FETCH: state <= S_WAIT;
        S_WAIT: if (mem_rd_valid) begin
          desc_q <= mem_rd_data;
          state  <= S_CHECK;
        end
        S_CHECK: begin
          code_q <= chk_code;
          lin_q  <= (chk_code == FLT_NONE) ? chk_lin : '0;
          state  <= (chk_code == FLT_NONE && chk_wb) ? S_WBACK : S_RESP;
        end
        S_WBACK: state <= S_RESP;
        S_RESP:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state != S_IDLE);
  assign done        = (state == S_RESP);
  assign fault       = (code_q != FLT_NONE);
  assign fault_code  = code_q;
  assign lin_addr    = lin_q;
  assign mem_rd_en   = (state == S_FETCH);
  assign mem_rd_addr = addr_q;
  assign mem_wr_en   = (state == S_WBACK);
  assign mem_wr_addr = addr_q;
  assign mem_wr_data = desc_q | (DW'(1) << ACC_BIT);
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [2:0]  fault_code,
  input logic        mem_rd_en,
  input logic [31:0] mem_rd_addr,
  input logic        mem_wr_en,
  input logic [31:0] mem_wr_addr,
  input logic [63:0] mem_wr_data
);
  logic        rd_seen, wr_seen;
  logic [31:0] rd_addr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen      <= 1'b0;
      wr_seen      <= 1'b0;
      rd_addr_seen <= '0;
    end else begin
      if (req_valid && !busy) begin
        rd_seen <= 1'b0;
        wr_seen <= 1'b0;
      end else begin
        if (mem_rd_en) begin
          rd_seen      <= 1'b1;
          rd_addr_seen <= mem_rd_addr;
        end
        if (mem_wr_en) wr_seen <= 1'b1;
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_rd_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en || done) |-> busy);
  assert_no_rd_wr_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  assert_tbl_fault_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_code == 3'd1) |-> !rd_seen);
  assert_wb_sets_accessed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_wr_data[40] && rd_seen && mem_wr_addr == rd_addr_seen));
  assert_no_wb_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> !wr_seen);
  assert_code_matches_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault == (fault_code != 3'd0)) && (fault_code <= 3'd5));
endmodule

bind seg_xlat seg_xlat_chk u_seg_xlat_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .fault(fault), .fault_code(fault_code), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data)
);

// File: tb/seg_xlat_tb.sv
module seg_xlat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GBASE = 32'h0000_0000;
  localparam logic [31:0] LBASE = 32'h0000_0100;
  localparam logic [15:0] GLIM  = 16'd127;
  localparam logic [15:0] LLIM  = 16'd63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic [1:0]  req_cpl = '0;
  logic        busy, done, fault;
  logic [2:0]  fault_code;
  logic [31:0] lin_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_rd_addr, mem_wr_addr;
  logic [63:0] mem_wr_data;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;

  logic [63:0] mem [0:63];
  int          wr_cnt = 0;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_off(req_off), .req_acc(req_acc), .req_cpl(req_cpl),
    .gtab_base(GBASE), .gtab_limit(GLIM), .ltab_base(LBASE), .ltab_limit(LLIM),
    .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
    .lin_addr(lin_addr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_en;
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[8:3]];
    if (mem_wr_en) begin
      mem[mem_wr_addr[8:3]] <= mem_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
      input logic [3:0] typ, input logic s, input logic [1:0] dpl, input logic p);
    logic [63:0] d = '0;
    d[15:0] = lim[15:0];   d[51:48] = lim[19:16];
    d[31:16] = base[15:0]; d[39:32] = base[23:16]; d[63:56] = base[31:24];
    d[43:40] = typ; d[44] = s; d[46:45] = dpl; d[47] = p;
    return d;
  endfunction

  // independent restatement of the requirements
  task automatic predict(input logic [15:0] sel, input logic [31:0] off,
      input logic [1:0] acc, input logic [1:0] cpl,
      output logic [2:0] ecode, output logic [31:0] elin, output int ewr, output int slot);
    int idx, tlim;
    logic [63:0] d;
    logic [31:0] lim, base;
    logic [1:0]  dpl, rpl, hi;
    logic [3:0]  t;
    bit is_code, rd_, wr_, ex_;
    idx  = int'(sel[15:3]);
    tlim = sel[2] ? int'(LLIM) : int'(GLIM);
    slot = (sel[2] ? 32 : 0) + idx;
    ecode = 3'd0; elin = 32'd0; ewr = 0;
    if (idx * 8 + 7 > tlim) begin ecode = 3'd1; return; end
    d = mem[slot];
    lim  = {12'd0, d[51:48], d[15:0]};
    base = {d[63:56], d[39:32], d[31:16]};
    t = d[43:40]; dpl = d[46:45]; rpl = sel[1:0];
    is_code = t[3]; rd_ = (acc == 2'd0); wr_ = (acc == 2'd1); ex_ = acc[1];
    hi = (rpl > cpl) ? rpl : cpl;
    if (!d[47]) ecode = 3'd2;
    else if (!d[44]) ecode = 3'd3;
    else if (is_code && wr_) ecode = 3'd3;
    else if (is_code && rd_ && !t[1]) ecode = 3'd3;
    else if (!is_code && ex_) ecode = 3'd3;
    else if (!is_code && wr_ && !t[1]) ecode = 3'd3;
    else if (!is_code && hi > dpl) ecode = 3'd4;
    else if (is_code && t[2] && dpl > cpl) ecode = 3'd4;
    else if (is_code && !t[2] && dpl != cpl) ecode = 3'd4;
    else if (!is_code && t[2] && !(off > lim)) ecode = 3'd5;
    else if (!(!is_code && t[2]) && off > lim) ecode = 3'd5;
    if (ecode == 3'd0) begin
      elin = base + off;
      ewr  = t[0] ? 0 : 1;
    end
  endtask

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xlat(input string req, input logic [15:0] sel, input logic [31:0] off,
                      input logic [1:0] acc, input logic [1:0] cpl);
    logic [2:0]  ecode;
    logic [31:0] elin;
    int ewr, slot, w0, n;
    predict(sel, off, acc, cpl, ecode, elin, ewr, slot);
    w0 = wr_cnt;
    @(negedge clk);
    req_sel = sel; req_off = off; req_acc = acc; req_cpl = cpl; req_valid = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end while (!done && n < 50);
    if (!done) begin
      checks++; errors++;
      $display("FAIL %s watchdog actual=no done expected=done", req);
      return;
    end
    check(req, "fault_code", 64'(fault_code), 64'(ecode));
    check(req, "fault", 64'(fault), 64'(ecode != 3'd0));
    check(req, "lin_addr", 64'(lin_addr), 64'(elin));
    check("R9", "writes", 64'(wr_cnt - w0), 64'(ewr));
    if (ewr == 1) check("R9", "accessed bit", 64'(mem[slot][40]), 64'd1);
    @(negedge clk);
    check("R10", "done pulse", 64'(done), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL global watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[1]  = mk_desc(32'h1000_0000, 20'h00FFF, 4'b0010, 1, 2'd3, 1); // rw data, not accessed
    mem[2]  = mk_desc(32'h2000_0000, 20'h00100, 4'b0111, 1, 2'd3, 1); // expand-down rw
    mem[3]  = mk_desc(32'h3000_0000, 20'h0FFFF, 4'b1011, 1, 2'd0, 1); // code nonconf readable
    mem[4]  = mk_desc(32'h4000_0000, 20'h0FFFF, 4'b1111, 1, 2'd0, 1); // code conforming
    mem[5]  = mk_desc(32'h5000_0000, 20'h00010, 4'b0010, 0, 2'd0, 0); // absent system
    mem[6]  = mk_desc(32'h6000_0000, 20'h00010, 4'b0011, 0, 2'd3, 1); // system
    mem[7]  = mk_desc(32'h7000_0000, 20'h00010, 4'b0001, 1, 2'd3, 1); // read-only data
    mem[8]  = mk_desc(32'h8000_0000, 20'h00010, 4'b0011, 1, 2'd2, 1); // data dpl 2
    mem[15] = mk_desc(32'hF000_0000, 20'hFFFFF, 4'b0011, 1, 2'd3, 1);
    mem[39] = mk_desc(32'h0ABC_0000, 20'h01000, 4'b0011, 1, 2'd3, 1); // local slot 7
    repeat (3) @(negedge clk);
    check("R10", "reset busy", 64'(busy), 64'd0);
    check("R10", "reset done", 64'(done), 64'd0);
    check("R10", "reset rd/wr", 64'({mem_rd_en, mem_wr_en}), 64'd0);
    rst_n = 1'b1;

    xlat("R3",  {13'd1, 1'b0, 2'd0}, 32'h0000_0FFF, 2'd1, 2'd3); // writes accessed (R9)
    xlat("R9",  {13'd1, 1'b0, 2'd0}, 32'h0000_0010, 2'd0, 2'd3); // no second write
    xlat("R7",  {13'd1, 1'b0, 2'd0}, 32'h0000_1000, 2'd0, 2'd3);
    xlat("R2",  {13'd15, 1'b0, 2'd3}, 32'h0000_0004, 2'd0, 2'd3);
    xlat("R2",  {13'd16, 1'b0, 2'd3}, 32'h0000_0004, 2'd0, 2'd3);
    xlat("R1",  {13'd7, 1'b1, 2'd3}, 32'h0000_0040, 2'd1, 2'd3);
    xlat("R2",  {13'd8, 1'b1, 2'd3}, 32'h0000_0040, 2'd1, 2'd3);
    xlat("R7",  {13'd2, 1'b0, 2'd3}, 32'h0000_0100, 2'd1, 2'd3);
    xlat("R7",  {13'd2, 1'b0, 2'd3}, 32'h0000_0101, 2'd1, 2'd3);
    xlat("R4",  {13'd5, 1'b0, 2'd0}, 32'h0, 2'd0, 2'd0);
    xlat("R5",  {13'd6, 1'b0, 2'd0}, 32'h0, 2'd0, 2'd0);
    xlat("R5",  {13'd3, 1'b0, 2'd0}, 32'h0, 2'd1, 2'd0);
    xlat("R5",  {13'd7, 1'b0, 2'd3}, 32'h0, 2'd1, 2'd3);
    xlat("R5",  {13'd7, 1'b0, 2'd3}, 32'h0, 2'd2, 2'd3);
    xlat("R6",  {13'd4, 1'b0, 2'd3}, 32'h0, 2'd2, 2'd3);
    xlat("R6",  {13'd3, 1'b0, 2'd3}, 32'h0, 2'd2, 2'd3);
    xlat("R6",  {13'd3, 1'b0, 2'd0}, 32'h0, 2'd2, 2'd0);
    xlat("R6",  {13'd8, 1'b0, 2'd3}, 32'h4, 2'd0, 2'd0);
    xlat("R8",  {13'd8, 1'b0, 2'd3}, 32'h40, 2'd0, 2'd0); // priv beats limit

    for (int i = 0; i < 48; i++) begin
      if (i == 16) i = 32;
      mem[i] = mk_desc($urandom, 20'($urandom % 4096), 4'($urandom),
                       ($urandom % 6) != 0, 2'($urandom), ($urandom % 8) != 0);
    end
    for (int k = 0; k < 400; k++) begin
      logic ti = 1'($urandom);
      logic [12:0] idx = ti ? 13'($urandom % 11) : 13'($urandom % 20);
      logic [31:0] off;
      int slot = (ti ? 32 : 0) + int'(idx);
      logic [31:0] lim = {12'd0, mem[slot % 64][51:48], mem[slot % 64][15:0]};
      off = ($urandom % 3 == 0) ? $urandom : lim + 32'($urandom % 5) - 32'd2;
      xlat("R8", {idx, ti, 2'($urandom)}, off, 2'($urandom), 2'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule